// File: doc/BRIEF.md
# Live-Time Expiring Replacement Set

This block chooses the line to replace in one set of a set-associative cache. Each way keeps a small saturating counter of how many hits its own line has received since it was filled. Each way also holds a threshold and a confidence flag, loaded at fill time from an external predictor. A confident way whose count has reached its threshold is treated as dead. On a miss, a dead way is replaced in preference to the least recently used one.

Each access presents a strobe, a hit flag and the hit way. On a miss, the block also takes the threshold and confidence for the incoming line. The block shows the current victim choice as a combinational output. One cycle after each miss it reports which way was evicted and the final hit count that way reached. That count is the observed live time, which the predictor stores for the next stay of the line. Tags, data and the predictor table are outside this block.

Top module: `ltx_repl_set`

## Requirements
- R1: After reset, every counter, threshold and confidence flag is zero, `evict_valid` is 0, and recency order ranks way i at age i. With 4 ways, the victim is way 3.
- R2: A hit (`acc_valid`=1, `acc_hit`=1) advances only the counter of way `acc_way`. Counters of other ways are unchanged.
- R3: Counters saturate at 15 (all ones for 4-bit width) and stay there under further hits.
- R4: A way is expired when its confidence flag is 1 and its counter is greater than or equal to its threshold. A threshold of 0 with confidence set means the way is expired at once.
- R5: A way whose confidence flag is 0 is never expired, whatever its counter and threshold.
- R6: When any way is expired, `victim_way` is the lowest-index expired way and `victim_expired` is 1.
- R7: When no way is expired, `victim_way` is the least recently used way and `victim_expired` is 0.
- R8: In the cycle after a miss (`acc_valid`=1, `acc_hit`=0), `evict_valid` is 1, `evict_way` is the way that was the victim, and `evict_live` is that way's counter value just before the fill. In all other cycles `evict_valid` is 0.
- R9: A miss fills the victim way. Its counter is cleared to 0, and it loads `fill_thr` and `fill_conf`.
- R10: The way that is hit or filled becomes most recently used. Ways that were more recent than it each age by one.
- R11: With `acc_valid`=0, no counter, threshold, confidence or recency state changes, and the hit, way and fill inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access to this set occurs this cycle |
| acc_hit | input | 1 | The access hit |
| acc_way | input | WAY_W (2) | Way that hit |
| fill_thr | input | CNT_W (4) | Live-time threshold for the incoming line |
| fill_conf | input | 1 | Confidence for the incoming line |
| victim_way | output | WAY_W (2) | Way replaced on a miss now |
| victim_expired | output | 1 | Victim was selected by expiry |
| evict_valid | output | 1 | Eviction report valid (cycle after a miss) |
| evict_way | output | WAY_W (2) | Way that was evicted |
| evict_live | output | CNT_W (4) | Observed live time of the evicted line |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally. A miss is always followed by an eviction report. A filled counter reads zero next cycle. A saturated counter stays saturated. An idle way keeps its count. Exactly one way is most recent. An expired victim really is expired. Only the bench's scenarios can show that hit counts accumulate in the right way over many accesses, that the lowest-index expired way wins over a different LRU way, and that the reported live time matches the count a line built up over its stay. The bench shows these by comparing against a reference model over directed saturation and expiry sequences and random traffic.

// File: rtl/ltx_pkg.sv
package ltx_pkg;
  localparam int unsigned LTX_DEF_WAYS  = 4;
  localparam int unsigned LTX_DEF_CNT_W = 4;
endpackage

// File: rtl/ltx_way_state.sv
module ltx_way_state #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic             fill_en,
  input  logic [CNT_W-1:0] fill_thr,
  input  logic             fill_conf,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] thr_q, thr_n;
  logic             conf_q, conf_n;
  logic             upd_en;

  always_comb begin
    cnt_n  = cnt_q;
    thr_n  = thr_q;
    conf_n = conf_q;
    upd_en = fill_en | hit_en;
    if (fill_en) begin
      cnt_n  = '0;
      thr_n  = fill_thr;
      conf_n = fill_conf;
    end else if (hit_en && cnt_q != CNT_MAX) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      thr_q  <= '0;
      conf_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_n;
      thr_q  <= thr_n;
      conf_q <= conf_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = conf_q && (cnt_q >= thr_q);

  AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (cnt_o == '0)); // R9
  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX && !fill_en) |=> (cnt_o == CNT_MAX)); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_en && !fill_en) |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/ltx_lru_age.sv
module ltx_lru_age #(
  parameter int unsigned WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch_en,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  output logic [$clog2(WAYS)-1:0] lru_way_o
);
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] age_q [WAYS];
  logic [WAY_W-1:0] age_n [WAYS];
  logic [WAYS-1:0]  mru_mask;

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      age_n[i] = age_q[i];
      if (touch_en) begin
        if (WAY_W'(i) == touch_way)          age_n[i] = '0;
        else if (age_q[i] < age_q[touch_way]) age_n[i] = age_q[i] + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age_q[g] <= WAY_W'(g);
        else if (touch_en) age_q[g] <= age_n[g];
      end
      assign mru_mask[g] = (age_q[g] == '0);
    end
  endgenerate

  always_comb begin
    lru_way_o = '0;
    for (int i = 0; i < WAYS; i++)
      if (age_q[i] == WAY_W'(WAYS - 1)) lru_way_o = WAY_W'(i);
  end

  AST_ONE_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mru_mask) == 1); // R10
endmodule

// File: rtl/ltx_victim_pick.sv
module ltx_victim_pick #(
  parameter int unsigned WAYS = 4
) (
  input  logic [WAYS-1:0]         exp_mask,
  input  logic [$clog2(WAYS)-1:0] lru_way,
  output logic [$clog2(WAYS)-1:0] victim_o,
  output logic                    by_exp_o
);
  localparam int unsigned WAY_W = $clog2(WAYS);

  always_comb begin
    victim_o = lru_way;
    by_exp_o = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (exp_mask[i]) begin
        victim_o = WAY_W'(i);
        by_exp_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ltx_repl_set.sv
module ltx_repl_set #(
  parameter int unsigned WAYS  = ltx_pkg::LTX_DEF_WAYS,
  parameter int unsigned CNT_W = ltx_pkg::LTX_DEF_CNT_W,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [CNT_W-1:0] fill_thr,
  input  logic             fill_conf,
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_expired,
  output logic             evict_valid,
  output logic [WAY_W-1:0] evict_way,
  output logic [CNT_W-1:0] evict_live
);
  logic [CNT_W-1:0] cnt_w [WAYS];
  logic [WAYS-1:0]  exp_mask;
  logic [WAY_W-1:0] lru_way;
  logic             miss_en;
  logic [WAY_W-1:0] touch_way;

  assign miss_en   = acc_valid && !acc_hit;
  assign touch_way = acc_hit ? acc_way : victim_way;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_way
      ltx_way_state #(.CNT_W(CNT_W)) way_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_en    (acc_valid && acc_hit && (acc_way == WAY_W'(g))),
        .fill_en   (miss_en && (victim_way == WAY_W'(g))),
        .fill_thr  (fill_thr),
        .fill_conf (fill_conf),
        .cnt_o     (cnt_w[g]),
        .expired_o (exp_mask[g])
      );
    end
  endgenerate

  ltx_lru_age #(.WAYS(WAYS)) lru_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (acc_valid),
    .touch_way (touch_way),
    .lru_way_o (lru_way)
  );

  ltx_victim_pick #(.WAYS(WAYS)) pick_i (
    .exp_mask (exp_mask),
    .lru_way  (lru_way),
    .victim_o (victim_way),
    .by_exp_o (victim_expired)
  );

  logic             ev_valid_n;
  logic [WAY_W-1:0] ev_way_n;
  logic [CNT_W-1:0] ev_live_n;

  always_comb begin
    ev_valid_n = miss_en;
    ev_way_n   = evict_way;
    ev_live_n  = evict_live;
    if (miss_en) begin
      ev_way_n  = victim_way;
      ev_live_n = cnt_w[victim_way];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evict_valid <= 1'b0;
      evict_way   <= '0;
      evict_live  <= '0;
    end else begin
      evict_valid <= ev_valid_n;
      evict_way   <= ev_way_n;
      evict_live  <= ev_live_n;
    end
  end

  AST_EVICT_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_en |=> (evict_valid && evict_way == $past(victim_way))); // R8
  AST_NO_EVICT_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_en |=> !evict_valid); // R8
  AST_EXPIRED_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    victim_expired |-> exp_mask[victim_way]); // R6
  AST_LRU_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_mask == '0) |-> (victim_way == lru_way)); // R7
endmodule

// File: tb/ltx_repl_set_tb.sv
module ltx_repl_set_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 4;
  localparam int WAY_W = 2;
  localparam int CNT_W = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_hit = 1'b0, fill_conf = 1'b0;
  logic [WAY_W-1:0] acc_way = '0;
  logic [CNT_W-1:0] fill_thr = '0;
  logic [WAY_W-1:0] victim_way, evict_way;
  logic             victim_expired, evict_valid;
  logic [CNT_W-1:0] evict_live;

  ltx_repl_set #(.WAYS(WAYS), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_way(acc_way), .fill_thr(fill_thr), .fill_conf(fill_conf),
    .victim_way(victim_way), .victim_expired(victim_expired),
    .evict_valid(evict_valid), .evict_way(evict_way), .evict_live(evict_live));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int m_cnt [WAYS];
  int m_thr [WAYS];
  int m_conf[WAYS];
  int m_age [WAYS];
  int p_valid = 0, p_way = 0, p_live = 0;
  string p_tag = "R8";
  bit p_idle = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_exp(input int w);
    return (m_conf[w] != 0) && (m_cnt[w] >= m_thr[w]);
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < WAYS; i++) if (m_exp(i)) return i;
    for (int i = 0; i < WAYS; i++) if (m_age[i] == WAYS - 1) return i;
    return 0;
  endfunction

  function automatic bit m_any_exp();
    for (int i = 0; i < WAYS; i++) if (m_exp(i)) return 1;
    return 0;
  endfunction

  function automatic bit m_unconf_reached();
    for (int i = 0; i < WAYS; i++)
      if (m_conf[i] == 0 && m_cnt[i] >= m_thr[i]) return 1;
    return 0;
  endfunction

  task automatic m_touch(input int w);
    for (int i = 0; i < WAYS; i++)
      if (i != w && m_age[i] < m_age[w]) m_age[i]++;
    m_age[w] = 0;
  endtask

  task automatic m_reset();
    for (int i = 0; i < WAYS; i++) begin
      m_cnt[i] = 0; m_thr[i] = 0; m_conf[i] = 0; m_age[i] = i;
    end
  endtask

  task automatic step(input bit v, input bit h, input int w, input int thr, input bit cf);
    int vic;
    string vt;
    @(negedge clk);
    chk(p_idle ? "R11 evict_valid" : "R8 evict_valid", int'(evict_valid), p_valid);
    if (p_valid != 0) begin
      chk("R8 evict_way", int'(evict_way), p_way);
      chk(p_tag, int'(evict_live), p_live);
    end
    acc_valid = v; acc_hit = h; acc_way = WAY_W'(w);
    fill_thr = CNT_W'(thr); fill_conf = cf;
    #1;
    vic = m_victim();
    if (m_any_exp()) vt = "R4/R6/R9 victim_way";
    else if (m_unconf_reached()) vt = "R5/R7 victim_way";
    else vt = "R7/R10 victim_way";
    chk(vt, int'(victim_way), vic);
    chk(m_any_exp() ? "R6 victim_expired" : "R7 victim_expired",
        int'(victim_expired), int'(m_any_exp()));
    @(posedge clk);
    p_idle = !v;
    p_valid = (v && !h) ? 1 : 0;
    if (v && h) begin
      if (m_cnt[w] < CMAX) m_cnt[w]++;
      m_touch(w);
    end else if (v) begin
      p_way = vic;
      p_live = m_cnt[vic];
      p_tag = (p_live == CMAX) ? "R3/R8 evict_live" : "R2/R8 evict_live";
      m_cnt[vic] = 0; m_thr[vic] = thr; m_conf[vic] = cf;
      m_touch(vic);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int seed;
    int r;
    seed = 32'h5eed_1234;
    r = int'($urandom(seed));
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 evict_valid", int'(evict_valid), 0);
    chk("R1 victim_way", int'(victim_way), WAYS - 1);
    chk("R1 victim_expired", int'(victim_expired), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: saturate way 3, then cycle it out through LRU misses
    for (int i = 0; i < 18; i++) step(1, 1, 3, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    // R11: idle cycles with noisy inputs
    for (int i = 0; i < 4; i++) step(0, i[0], i, 7, 1);
    // R5: unconfident zero threshold fills, then R4/R6: confident fills
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 2, 1);
    step(1, 1, 1, 0, 0);
    step(1, 1, 2, 0, 0);
    step(1, 1, 3, 0, 0);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 3, 1);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      int k, w, t;
      bit cf;
      k  = int'($urandom % 10);
      w  = int'($urandom % WAYS);
      t  = int'($urandom % 6);
      cf = 1'($urandom % 2);
      if (k < 6)      step(1, 1, w, t, cf);
      else if (k < 9) step(1, 0, w, t, cf);
      else            step(0, 1, w, t, cf);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule